// File: doc/BRIEF.md
# Flash Busy Status Reporter

This block sits between the array read path of a byte-wide flash model and its data pins. While an embedded program or erase is running, it overwrites the two top bits of every byte read, so the host can poll for completion. Once the operation is over, the block returns array data unchanged.

Two status mechanisms are used, and they do not depend on each other:
- The polling bit carries a value whose polarity depends on the operation. During an erase it reads 0. During a program it reads the complement of the top bit of the byte being written.
- The toggle bit flips once on every new read access, whatever the address.

The busy interval itself is generated elsewhere. At its first cycle the block captures three things:
- the operation type;
- the byte being written;
- whether that byte would need any cell to go from 0 back to 1.

A write that needs such a change is treated as a failed program, and the toggle bit then freezes. All outputs are registered, so each sampled input appears on the pins one clock later.

Top module: `busy_status_rpt`

## Requirements
- R1: While `rst` is high, on the following clock `dq_oe_o` is 0, `dq_o` is 0x00 and the toggle state is cleared to 0.
- R2: `dq_oe_o` is 1 one clock after a cycle in which `ce_n_i` and `oe_n_i` are both 0, and 0 one clock after any other cycle.
- R3: When `busy_i` is 0, `dq_o` equals `rdata_i` of the previous cycle in all eight bits.
- R4: During a program (`erase_i`=0 at the first busy cycle), bit 7 of `dq_o` is the inverse of bit 7 of `wdata_i` as captured at that first busy cycle.
- R5: During an erase (`erase_i`=1 at the first busy cycle), bit 7 of `dq_o` is 0.
- R6: While busy, bit 6 of `dq_o` inverts once for each read access. A read access is the first cycle of a run of cycles with `ce_n_i` and `oe_n_i` both 0. It holds its value during an access and between accesses.
- R7: A new access may be opened by raising and lowering either `ce_n_i` or `oe_n_i`. Either way it flips bit 6.
- R8: While busy, bits 5..0 of `dq_o` equal bits 5..0 of the previous cycle's `rdata_i`.
- R9: On the first read after `busy_i` falls, `dq_o` returns the true array byte, bits 7 and 6 included.
- R10: A program whose byte has a 1 where `rdata_i` holds a 0 at the first busy cycle is a failed program. For that busy interval, bit 6 no longer flips on accesses.
- R11: Changes of `erase_i` and `wdata_i` after the first busy cycle have no effect on the status bits until the next busy interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Embedded operation in progress |
| erase_i | input | 1 | Operation type at busy start: 1 erase, 0 program |
| wdata_i | input | DATA_W | Byte being programmed, captured at busy start |
| rdata_i | input | DATA_W | Array byte at the addressed location |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dq_o | output | DATA_W | Registered read data with status bits |
| dq_oe_o | output | 1 | Registered pin drive enable (0 means high impedance) |

## Verification
The bench builds the block with its default `DATA_W` of 8. At that width the polling bit sits at bit 7 and the toggle bit at bit 6, and the table values can be written as plain hex bytes.

The vectors cover several sequences:
- a program polled with accesses opened from output enable and then from chip enable;
- an erase started with a different toggle phase;
- the true byte appearing on the first read after each operation.

Directed tests then cover:
- a failed program whose toggle bit must stay still;
- a program of a byte with bit 7 clear, which flips the polling polarity;
- a reset taken in the middle of a busy interval.

// File: rtl/busy_status_pkg.sv
package busy_status_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_e;
endpackage

// File: rtl/bsr_access_det.sv
// Combined read enable and start-of-access pulse.
module bsr_access_det (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_i,
  input  logic oe_n_i,
  output logic rd_en_o,
  output logic access_o
);
  logic rd_en_q;

  assign rd_en_o  = ~ce_n_i & ~oe_n_i;
  assign access_o = rd_en_o & ~rd_en_q;

  always_ff @(posedge clk) begin
    if (rst) rd_en_q <= 1'b0;
    else     rd_en_q <= rd_en_o;
  end

  // R6: an access pulse never repeats in back-to-back cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    access_o |=> !access_o);
endmodule

// File: rtl/bsr_op_latch.sv
// Captures operation type, top data bit and program conflict at busy start.
module bsr_op_latch
  import busy_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output op_e               op_o,
  output logic              wtop_o,
  output logic              fail_o
);
  localparam int TOP = DATA_W - 1;

  logic busy_q;
  op_e  op_q;
  logic wtop_q;
  logic fail_q;
  logic start;
  op_e  op_now;
  logic clash_now;

  assign start     = busy_i & ~busy_q;
  assign op_now    = op_e'(erase_i);
  assign clash_now = (op_now == OP_PROG) && (|(wdata_i & ~rdata_i));

  assign op_o   = start ? op_now     : op_q;
  assign wtop_o = start ? wdata_i[TOP] : wtop_q;
  assign fail_o = start ? clash_now  : fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      op_q   <= OP_PROG;
      wtop_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (start) begin
        op_q   <= op_now;
        wtop_q <= wdata_i[TOP];
        fail_q <= clash_now;
      end else if (!busy_i) begin
        fail_q <= 1'b0;
      end
    end
  end

  // R11: captured operation holds through a busy interval
  a_r11_op_held: assert property (@(posedge clk) disable iff (rst)
    (busy_i && busy_q) |-> (op_o == op_q));
endmodule

// File: rtl/bsr_toggle.sv
// Toggle-bit state: flips once per read access while busy and not failed.
module bsr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic access_i,
  input  logic fail_i,
  output logic tog_next_o
);
  logic tog_q;

  assign tog_next_o = (busy_i && access_i && !fail_i) ? ~tog_q : tog_q;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_next_o;
  end

  // R6: an access during a healthy operation flips the state
  a_r6_flip: assert property (@(posedge clk) disable iff (rst)
    (busy_i && access_i && !fail_i) |=> (tog_q != $past(tog_q)));
  // R10: a failed program freezes the state
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy_i && fail_i) |=> $stable(tog_q));
  // R9: no flipping outside an operation
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !busy_i |=> $stable(tog_q));
endmodule

// File: rtl/busy_status_rpt.sv
module busy_status_rpt
  import busy_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic rd_en;
  logic access;
  op_e  op_cur;
  logic wtop_cur;
  logic fail_cur;
  logic tog_next;
  logic [DATA_W-1:0] dq_d;

  bsr_access_det u_acc (
    .clk(clk), .rst(rst), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .rd_en_o(rd_en), .access_o(access)
  );

  bsr_op_latch #(.DATA_W(DATA_W)) u_op (
    .clk(clk), .rst(rst), .busy_i(busy_i), .erase_i(erase_i),
    .wdata_i(wdata_i), .rdata_i(rdata_i),
    .op_o(op_cur), .wtop_o(wtop_cur), .fail_o(fail_cur)
  );

  bsr_toggle u_tog (
    .clk(clk), .rst(rst), .busy_i(busy_i), .access_i(access),
    .fail_i(fail_cur), .tog_next_o(tog_next)
  );

  always_comb begin
    dq_d = rdata_i;
    if (busy_i) begin
      dq_d[POLL_BIT] = (op_cur == OP_ERASE) ? 1'b0 : ~wtop_cur;
      dq_d[TOG_BIT]  = tog_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      dq_o    <= dq_d;
      dq_oe_o <= rd_en;
    end
  end

  // R2: pins driven only after both enables were low
  a_r2_drive: assert property (@(posedge clk) disable iff (rst)
    (ce_n_i || oe_n_i) |=> !dq_oe_o);
  // R3: idle cycles pass array data
  a_r3_pass: assert property (@(posedge clk) disable iff (rst)
    !busy_i |=> (dq_o == $past(rdata_i)));
  // R5: erase shows 0 on the polling bit
  a_r5_erase_poll: assert property (@(posedge clk) disable iff (rst)
    (busy_i && op_cur == OP_ERASE) |=> !dq_o[POLL_BIT]);
  // R8: low bits carry array data while busy
  a_r8_low_bits: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (dq_o[TOG_BIT-1:0] == $past(rdata_i[TOG_BIT-1:0])));
endmodule

// File: tb/tb_busy_status_rpt.sv
module tb_busy_status_rpt;
  logic       clk = 1'b0;
  logic       rst;
  logic       busy, erase;
  logic [7:0] wdata, rdata;
  logic       ce_n, oe_n;
  logic [7:0] dq;
  logic       dq_oe;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  busy_status_rpt #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .busy_i(busy), .erase_i(erase),
    .wdata_i(wdata), .rdata_i(rdata), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .dq_o(dq), .dq_oe_o(dq_oe)
  );

  typedef struct packed {
    logic       b;
    logic       e;
    logic [7:0] w;
    logic [7:0] r;
    logic       ce;
    logic       oe;
    logic       xoe;
    logic [7:0] xdq;
  } vec_t;

  // busy erase wdata rdata ce_n oe_n | exp_oe exp_dq
  localparam vec_t TBL [15] = '{
    '{1'b0,1'b0,8'h00,8'hA5,1'b1,1'b1,1'b0,8'hA5}, // R3 idle, undriven
    '{1'b0,1'b0,8'h00,8'h3C,1'b0,1'b0,1'b1,8'h3C}, // R2 R3 idle read
    '{1'b1,1'b0,8'h80,8'hFF,1'b1,1'b1,1'b0,8'h3F}, // R4 program start
    '{1'b1,1'b1,8'h00,8'hFF,1'b0,1'b0,1'b1,8'h7F}, // R6 R11 access flips
    '{1'b1,1'b0,8'h00,8'hFF,1'b0,1'b0,1'b1,8'h7F}, // R6 held access
    '{1'b1,1'b0,8'h00,8'hFF,1'b0,1'b1,1'b0,8'h7F}, // R6 oe high
    '{1'b1,1'b0,8'h00,8'hFF,1'b0,1'b0,1'b1,8'h3F}, // R7 oe reopen
    '{1'b1,1'b0,8'h00,8'hFF,1'b1,1'b0,1'b0,8'h3F}, // R7 ce high
    '{1'b1,1'b0,8'h00,8'hFF,1'b0,1'b0,1'b1,8'h7F}, // R7 ce reopen
    '{1'b0,1'b0,8'h00,8'h80,1'b0,1'b0,1'b1,8'h80}, // R9 true data
    '{1'b1,1'b1,8'h00,8'h12,1'b1,1'b1,1'b0,8'h52}, // R5 erase start
    '{1'b1,1'b1,8'h00,8'h12,1'b0,1'b0,1'b1,8'h12}, // R5 R6 access
    '{1'b1,1'b1,8'h00,8'h2D,1'b1,1'b0,1'b0,8'h2D}, // R8 low bits
    '{1'b1,1'b1,8'h00,8'h2D,1'b0,1'b0,1'b1,8'h6D}, // R6 access
    '{1'b0,1'b0,8'h00,8'hFF,1'b0,1'b0,1'b1,8'hFF}  // R9 true data
  };

  task automatic drive(input logic b, input logic e, input logic [7:0] w,
                       input logic [7:0] r, input logic c, input logic o);
    busy = b; erase = e; wdata = w; rdata = r; ce_n = c; oe_n = o;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic xoe, input logic [7:0] xdq);
    checks++;
    if (dq_oe !== xoe || dq !== xdq) begin
      errors++;
      $display("FAIL %s: got oe=%0b dq=%02h, expected oe=%0b dq=%02h",
               req, dq_oe, dq, xoe, xdq);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected at most 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    busy = 0; erase = 0; wdata = 0; rdata = 8'hC3; ce_n = 1; oe_n = 1;
    @(negedge clk); @(negedge clk);
    check("R1 reset", 1'b0, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < 15; i++) begin
      drive(TBL[i].b, TBL[i].e, TBL[i].w, TBL[i].r, TBL[i].ce, TBL[i].oe);
      check($sformatf("R2-R11 vector %0d", i), TBL[i].xoe, TBL[i].xdq);
    end
    // toggle state is now 1

    // R10: conflicting program (0x81 over 0x7E), toggle frozen at 1
    drive(1, 0, 8'h81, 8'h7E, 1, 1);
    check("R10 fail start", 1'b0, 8'h7E & 8'h7F);   // poll=~1=0, tog=1, low=3E
    drive(1, 0, 8'h81, 8'h7E, 0, 0);
    check("R10 access 1", 1'b1, 8'h7E);
    drive(1, 0, 8'h81, 8'h7E, 1, 1);
    drive(1, 0, 8'h81, 8'h7E, 0, 0);
    check("R10 access 2", 1'b1, 8'h7E);
    drive(0, 0, 8'h00, 8'h7E, 1, 1);
    check("R9 after fail", 1'b0, 8'h7E);

    // R4: program of 0x00 over 0xFF, poll=1; first access flips tog to 0
    drive(1, 0, 8'h00, 8'hFF, 1, 1);
    check("R4 poll one", 1'b0, 8'hFF);
    drive(1, 1, 8'hFF, 8'hFF, 0, 0);
    check("R4 R11 access", 1'b1, 8'hBF);

    // R1: reset during busy clears drive, data and toggle state
    rst = 1'b1;
    drive(1, 0, 8'h00, 8'hFF, 0, 0);
    check("R1 reset in busy", 1'b0, 8'h00);
    rst = 1'b0;
    drive(1, 0, 8'h00, 8'hFF, 1, 1);
    drive(1, 0, 8'h00, 8'hFF, 0, 0);
    check("R1 toggle cleared then R6 flip", 1'b1, 8'hFF);
    drive(0, 0, 8'h00, 8'h5A, 1, 1);
    check("R3 idle after", 1'b0, 8'h5A);

    finish_run();
  end
endmodule